// File: doc/BRIEF.md
# Instruction Prefetch Queue with Queue Status Reporting

This block is a byte-wide instruction queue that sits between a 16-bit code-fetch port and an instruction execution side. The fetch side fills the queue with either a whole word, when the fetch pointer is even, or a single byte taken from the high lane, when the pointer is odd. The execution side takes bytes from the head. Each take is marked as the first byte of an instruction or as a subsequent byte. A flush empties the queue, loads a new fetch pointer and abandons any fetch that is still pending.

The queue decides on its own when a code fetch may start. It holds at most six bytes while the fetch pointer is even and at most five while it is odd. It asks for a fetch only while at least two byte slots are free. After a byte is taken from a full queue it stays quiet for two more cycles before it asks again. A two-bit status output, together with a byte output, reports one cycle late which queue operation happened. The queue can be preloaded during reset, and the fetch pointer then starts just past the preloaded bytes.

The fetch controller is a four-state machine:
- `F_IDLE`: no request.
- `F_REQ`: a request is outstanding.
- `F_HOLD1` and `F_HOLD2`: the two quiet cycles after a take from a full queue.

Its transitions:
- `F_IDLE` → `F_HOLD1` on a take from a full queue.
- `F_IDLE` → `F_REQ` when at most four bytes are held.
- `F_REQ` → `F_IDLE` on an acknowledge.
- `F_HOLD1` → `F_HOLD2` always.
- `F_HOLD2` → `F_REQ` when at most four bytes are held, otherwise `F_HOLD2` → `F_IDLE`.
- Any state → `F_IDLE` on a flush.

Top module: `pfq_top`

## Requirements
- R1: During synchronous reset (`rst_n` low) the queue loads `init_count` bytes from `init_data`, byte k at bits [8k+7:8k], with byte 0 at the head. `init_count` is clamped to 6. After reset `fetch_addr` equals `init_ptr` plus that count, `qs` is 00 and `qs_byte` is 00.
- R2: `head_byte` always shows the oldest stored byte, and bytes leave in arrival order. `pop_ready` is high exactly when the queue is not empty. A take request while the queue is empty is ignored and changes nothing.
- R3: The queue is full at 6 bytes with an even `fetch_addr` and at 5 bytes with an odd one. `fetch_req` is never high while more than 4 bytes are held.
- R4: An acknowledge of a request at an even `fetch_addr` appends `fetch_data[7:0]` and then `fetch_data[15:0]`'s high byte `fetch_data[15:8]`, and advances `fetch_addr` by 2.
- R5: An acknowledge of a request at an odd `fetch_addr` appends only `fetch_data[15:8]` and advances `fetch_addr` by 1. The address wraps modulo 2^20.
- R6: After a byte is taken from a full queue, `fetch_req` stays low for the next two cycles. It rises in the third cycle if at most 4 bytes are then held.
- R7: One cycle after a take, `qs` is 01 if `pop_first` was high, or 11 if only `pop_next` was high. `qs_byte` holds the byte taken.
- R8: `flush` overrides a take and an acknowledge in the same cycle. In the next cycle the queue is empty, `fetch_addr` equals `flush_ptr`, `fetch_req` is low, `qs` is 10 and `qs_byte` is 00.
- R9: One cycle after a cycle with neither a take nor a flush, `qs` is 00 and `qs_byte` is 00.
- R10: Once raised, `fetch_req` stays high and `fetch_addr` stays stable until an acknowledge or a flush. It rises one cycle after an idle cycle in which at most 4 bytes are held. `fetch_ack` without `fetch_req` is ignored.
- R11: A queue preloaded to full at reset raises no `fetch_req` until its first byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; loads the preload values |
| init_data | input | 48 | Preload bytes, byte 0 at the head |
| init_count | input | 3 | Number of preloaded bytes |
| init_ptr | input | 20 | Fetch pointer before the preloaded bytes |
| flush | input | 1 | Empty the queue and restart fetching |
| flush_ptr | input | 20 | New fetch pointer loaded on a flush |
| pop_first | input | 1 | Take the head byte as an instruction first byte |
| pop_next | input | 1 | Take the head byte as a subsequent byte |
| pop_ready | output | 1 | Queue holds at least one byte |
| head_byte | output | 8 | Oldest byte in the queue |
| fetch_req | output | 1 | Code fetch request |
| fetch_addr | output | 20 | Address of the requested fetch |
| fetch_ack | input | 1 | Fetch completes, data valid this cycle |
| fetch_data | input | 16 | Fetched word, even byte on the low lane |
| qs | output | 2 | Previous-cycle queue operation: 00 none, 01 first, 10 flush, 11 subsequent |
| qs_byte | output | 8 | Byte taken in the previous cycle, 00 otherwise |

## Verification
The bench targets the full-queue boundary at both address parities:
- A design that counted an odd pointer's capacity as six would never see the queue as full, and would skip the two-cycle pause or fetch into a full queue.
- A design that pushed the low lane on an odd fetch would insert the wrong byte.

A take from a preloaded full queue checks that no request leaks out before the first take and that the pause is exactly two cycles long. Flushes landing together with takes and acknowledges catch a design that keeps a discarded byte or reports a take instead of a flush. Takes from an empty queue catch a status report for a byte that never existed.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        QS_NONE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qs_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_REQ,
        F_HOLD1,
        F_HOLD2
    } fst_e;
endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [8*DEPTH-1:0] init_data,
    input  logic [CNT_W-1:0]   init_cnt,
    input  logic               clr,
    input  logic               pop,
    input  logic               push_a,
    input  logic               push_b,
    input  logic [7:0]         byte_a,
    input  logic [7:0]         byte_b,
    output logic [7:0]         head,
    output logic [CNT_W-1:0]   count
);
    logic [7:0]       slot     [DEPTH];
    logic [7:0]       slot_nxt [DEPTH];
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] base_b;

    assign base   = count - {{(CNT_W-1){1'b0}}, pop};
    assign base_b = base + {{(CNT_W-1){1'b0}}, 1'b1};
    assign head   = slot[0];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [7:0] shifted;
        if (i < DEPTH - 1) begin : g_mid
            assign shifted = pop ? slot[i+1] : slot[i];
        end else begin : g_last
            assign shifted = pop ? 8'h00 : slot[i];
        end

        always_comb begin
            slot_nxt[i] = shifted;
            if (push_a && base == CNT_W'(i)) begin
                slot_nxt[i] = byte_a;
            end else if (push_b && base_b == CNT_W'(i)) begin
                slot_nxt[i] = byte_b;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= init_data[8*i +: 8];
            end else begin
                slot[i] <= slot_nxt[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= init_cnt;
        end else if (clr) begin
            count <= '0;
        end else begin
            count <= base + CNT_W'(push_a) + CNT_W'(push_b);
        end
    end
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
    import pfq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 6,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] init_ptr,
    input  logic [CNT_W-1:0]  init_cnt,
    input  logic [CNT_W-1:0]  count,
    input  logic              pop_ok,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_ptr,
    input  logic              fetch_ack,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              push_a,
    output logic              push_b
);
    localparam logic [CNT_W-1:0] CAP_EVEN = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_ODD  = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(DEPTH - 2);

    fst_e              state, state_nxt;
    logic [ADDR_W-1:0] ptr;
    logic              room;
    logic              from_full;
    logic              take;

    assign room      = count <= ROOM_MAX;
    assign from_full = pop_ok && (count == (ptr[0] ? CAP_ODD : CAP_EVEN));
    assign take      = (state == F_REQ) && fetch_ack && !flush;

    always_comb begin
        state_nxt = state;
        if (flush) begin
            state_nxt = F_IDLE;
        end else begin
            unique case (state)
                F_IDLE:  state_nxt = from_full ? F_HOLD1 : (room ? F_REQ : F_IDLE);
                F_REQ:   state_nxt = fetch_ack ? F_IDLE : F_REQ;
                F_HOLD1: state_nxt = F_HOLD2;
                F_HOLD2: state_nxt = room ? F_REQ : F_IDLE;
                default: state_nxt = F_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= F_IDLE;
            ptr   <= init_ptr + ADDR_W'(init_cnt);
        end else begin
            state <= state_nxt;
            if (flush) begin
                ptr <= flush_ptr;
            end else if (take) begin
                ptr <= ptr + (ptr[0] ? ADDR_W'(1) : ADDR_W'(2));
            end
        end
    end

    always_comb begin
        fetch_req  = (state == F_REQ);
        fetch_addr = ptr;
        push_a     = take;
        push_b     = take && !ptr[0];
    end
endmodule

// File: rtl/pfq_status.sv
module pfq_status
    import pfq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       pop_ok,
    input  logic       pop_first,
    input  logic [7:0] head,
    output logic [1:0] qs,
    output logic [7:0] qs_byte
);
    qs_e        code_nxt;
    logic [7:0] byte_nxt;

    always_comb begin
        code_nxt = QS_NONE;
        byte_nxt = 8'h00;
        if (flush) begin
            code_nxt = QS_FLUSH;
        end else if (pop_ok) begin
            code_nxt = pop_first ? QS_FIRST : QS_NEXT;
            byte_nxt = head;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qs      <= QS_NONE;
            qs_byte <= 8'h00;
        end else begin
            qs      <= code_nxt;
            qs_byte <= byte_nxt;
        end
    end
endmodule

// File: rtl/pfq_top.sv
module pfq_top #(
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [8*DEPTH-1:0] init_data,
    input  logic [CNT_W-1:0]   init_count,
    input  logic [ADDR_W-1:0]  init_ptr,
    input  logic               flush,
    input  logic [ADDR_W-1:0]  flush_ptr,
    input  logic               pop_first,
    input  logic               pop_next,
    output logic               pop_ready,
    output logic [7:0]         head_byte,
    output logic               fetch_req,
    output logic [ADDR_W-1:0]  fetch_addr,
    input  logic               fetch_ack,
    input  logic [15:0]        fetch_data,
    output logic [1:0]         qs,
    output logic [7:0]         qs_byte
);
    logic [CNT_W-1:0] init_cnt_c;
    logic [CNT_W-1:0] q_count;
    logic             pop_ok;
    logic             push_a;
    logic             push_b;
    logic [7:0]       byte_a;

    assign init_cnt_c = (init_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : init_count;
    assign pop_ready  = q_count != '0;
    assign pop_ok     = (pop_first || pop_next) && pop_ready && !flush;
    assign byte_a     = fetch_addr[0] ? fetch_data[15:8] : fetch_data[7:0];

    pfq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_data (init_data),
        .init_cnt  (init_cnt_c),
        .clr       (flush),
        .pop       (pop_ok),
        .push_a    (push_a),
        .push_b    (push_b),
        .byte_a    (byte_a),
        .byte_b    (fetch_data[15:8]),
        .head      (head_byte),
        .count     (q_count)
    );

    pfq_fetch #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_ptr   (init_ptr),
        .init_cnt   (init_cnt_c),
        .count      (q_count),
        .pop_ok     (pop_ok),
        .flush      (flush),
        .flush_ptr  (flush_ptr),
        .fetch_ack  (fetch_ack),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .push_a     (push_a),
        .push_b     (push_b)
    );

    pfq_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .pop_ok    (pop_ok),
        .pop_first (pop_first),
        .head      (head_byte),
        .qs        (qs),
        .qs_byte   (qs_byte)
    );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int ADDR_W = 20,
    parameter int DEPTH  = 6,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              pop_first,
    input logic              pop_next,
    input logic              pop_ready,
    input logic              fetch_req,
    input logic              fetch_ack,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [CNT_W-1:0]  q_count,
    input logic [1:0]        qs,
    input logic [7:0]        qs_byte
);
    logic             took;
    logic [CNT_W-1:0] cap;

    assign took = (pop_first || pop_next) && pop_ready && !flush;
    assign cap  = fetch_addr[0] ? CNT_W'(DEPTH - 1) : CNT_W'(DEPTH);

    assert_no_req_crowded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (q_count <= CNT_W'(DEPTH - 2)));

    assert_even_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack && !flush && !fetch_addr[0])
        |=> fetch_addr == $past(fetch_addr) + ADDR_W'(2));

    assert_odd_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack && !flush && fetch_addr[0])
        |=> fetch_addr == $past(fetch_addr) + ADDR_W'(1));

    assert_full_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (took && q_count == cap) |=> !fetch_req ##1 !fetch_req);

    assert_first_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (took && pop_first) |=> qs == 2'b01);

    assert_next_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (took && !pop_first) |=> qs == 2'b11);

    assert_flush_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (qs == 2'b10 && qs_byte == 8'h00 && !pop_ready && !fetch_req));

    assert_quiet_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !took) |=> (qs == 2'b00 && qs_byte == 8'h00));

    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_ack && !flush) |=> (fetch_req && $stable(fetch_addr)));
endmodule

bind pfq_top pfq_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .pop_first  (pop_first),
    .pop_next   (pop_next),
    .pop_ready  (pop_ready),
    .fetch_req  (fetch_req),
    .fetch_ack  (fetch_ack),
    .fetch_addr (fetch_addr),
    .q_count    (q_count),
    .qs         (qs),
    .qs_byte    (qs_byte)
);

// File: tb/test_pfq_top.sv
`timescale 1ns/1ps
module test_pfq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] init_data = '0;
    logic [2:0]  init_count = '0;
    logic [19:0] init_ptr = '0;
    logic        flush = 1'b0;
    logic [19:0] flush_ptr = '0;
    logic        pop_first = 1'b0;
    logic        pop_next = 1'b0;
    logic        pop_ready;
    logic [7:0]  head_byte;
    logic        fetch_req;
    logic [19:0] fetch_addr;
    logic        fetch_ack = 1'b0;
    logic [15:0] fetch_data = '0;
    logic [1:0]  qs;
    logic [7:0]  qs_byte;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pfq_top i_pfq_top (
        .clk(clk), .rst_n(rst_n), .init_data(init_data), .init_count(init_count),
        .init_ptr(init_ptr), .flush(flush), .flush_ptr(flush_ptr),
        .pop_first(pop_first), .pop_next(pop_next), .pop_ready(pop_ready),
        .head_byte(head_byte), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .fetch_data(fetch_data), .qs(qs), .qs_byte(qs_byte)
    );

    // Reference model built from the requirements
    logic [7:0]  mq [0:7];
    int          mcnt, mst, mqs, mqb, c0, cap;
    logic [19:0] mptr;
    logic        mpop, mff, mtake;
    string       addr_tag = "R1";

    function automatic int clamp6(input int c);
        return (c > 6) ? 6 : c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt = clamp6(int'(init_count));
            for (int k = 0; k < 8; k++) mq[k] = (k < 6) ? init_data[8*k +: 8] : 8'h00;
            mptr = init_ptr + 20'(mcnt);
            mst = 0; mqs = 0; mqb = 0; addr_tag = "R1";
        end else begin
            c0 = mcnt;
            cap = mptr[0] ? 5 : 6;
            mpop = (pop_first || pop_next) && c0 > 0 && !flush;
            mff = mpop && c0 == cap;
            mtake = mst == 1 && fetch_ack && !flush;
            if (flush) begin mqs = 2; mqb = 0; end
            else if (mpop) begin mqs = pop_first ? 1 : 3; mqb = int'(mq[0]); end
            else begin mqs = 0; mqb = 0; end
            if (flush) begin
                mcnt = 0; mptr = flush_ptr; mst = 0; addr_tag = "R8";
            end else begin
                if (mpop) begin
                    for (int k = 0; k < 7; k++) mq[k] = mq[k+1];
                    mcnt = mcnt - 1;
                end
                if (mtake) begin
                    if (mptr[0]) begin
                        mq[mcnt] = fetch_data[15:8]; mcnt = mcnt + 1;
                        mptr = mptr + 20'd1; addr_tag = "R5";
                    end else begin
                        mq[mcnt] = fetch_data[7:0]; mq[mcnt+1] = fetch_data[15:8];
                        mcnt = mcnt + 2; mptr = mptr + 20'd2; addr_tag = "R4";
                    end
                end
                case (mst)
                    0: mst = mff ? 2 : (c0 <= 4 ? 1 : 0);
                    1: mst = mtake ? 0 : 1;
                    2: mst = 3;
                    default: mst = (c0 <= 4) ? 1 : 0;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        string rt, qt;
        chk("R2 ready", 32'(pop_ready), 32'(mcnt > 0));
        if (mcnt > 0) chk("R2 head", 32'(head_byte), 32'(mq[0]));
        rt = (mst == 2 || mst == 3) ? "R6 req" : ((mcnt > 4) ? "R3 req" : "R10 req");
        chk(rt, 32'(fetch_req), 32'(mst == 1));
        chk(addr_tag, 32'(fetch_addr), 32'(mptr));
        qt = (mqs == 2) ? "R8 qs" : ((mqs == 0) ? "R9 qs" : "R7 qs");
        chk(qt, 32'(qs), 32'(mqs));
        chk(qt, 32'(qs_byte), 32'(mqb));
    endtask

    task automatic do_reset(input logic [47:0] d, input int cnt, input logic [19:0] p);
        @(negedge clk);
        rst_n = 1'b0; init_data = d; init_count = 3'(cnt); init_ptr = p;
        flush = 0; pop_first = 0; pop_next = 0; fetch_ack = 0;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state, expected values straight from the preload inputs
        chk("R1 addr", 32'(fetch_addr), 32'(p + 20'(clamp6(cnt))));
        chk("R1 qs", 32'(qs), 32'd0);
        chk("R1 qsbyte", 32'(qs_byte), 32'd0);
        chk("R1 ready", 32'(pop_ready), 32'(cnt > 0));
        if (cnt > 0) chk("R1 head", 32'(head_byte), 32'(d[7:0]));
        rst_n = 1'b1;
    endtask

    task automatic step(input bit pf, input bit pn, input bit fl, input logic [19:0] fp, input bit ak);
        @(negedge clk);
        check_all();
        pop_first = pf; pop_next = pn; flush = fl; flush_ptr = fp;
        fetch_ack = ak; fetch_data = 16'($urandom);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        // Preloaded full queue at an even pointer
        do_reset(48'h665544332211, 6, 20'h00100);
        for (int k = 0; k < 4; k++) begin
            step(0, 0, 0, 0, 0);
            chk("R11 no req", 32'(fetch_req), 32'd0);
        end
        step(1, 0, 0, 0, 0);                 // take first byte from full queue
        for (int k = 0; k < 8; k++) step(0, 1, 0, 0, 1);
        // Preloaded full queue at an odd pointer (5 bytes)
        do_reset(48'h0000_A5B4C3D2E1, 5, 20'h00FF0);
        for (int k = 0; k < 3; k++) begin
            step(0, 0, 0, 0, 0);
            chk("R11 no req odd", 32'(fetch_req), 32'd0);
        end
        step(0, 1, 0, 0, 0);
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1);
        // Empty start at the top of the address space: odd byte fetch then wrap
        do_reset(48'h0, 0, 20'hFFFFF);
        step(0, 1, 0, 0, 0);                 // take on empty queue is ignored
        for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 1);
        // Flush colliding with a take and an acknowledge
        step(1, 0, 1, 20'h12345, 1);
        for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1);
        step(0, 1, 1, 20'h00010, 1);
        for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 0);
        // Constrained random traffic in phases of different take rates
        for (int ph = 0; ph < 6; ph++) begin
            int pr;
            pr = (ph % 3 == 0) ? 10 : ((ph % 3 == 1) ? 50 : 90);
            for (int k = 0; k < 500; k++) begin
                bit pf, pn, fl, ak;
                pf = ($urandom % 100) < pr / 2;
                pn = ($urandom % 100) < pr;
                fl = ($urandom % 100) < 3;
                ak = ($urandom % 100) < 60;
                step(pf, pn, fl, 20'($urandom), ak);
            end
        end
        step(0, 0, 0, 0, 0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule